// File: doc/BRIEF.md
# Page Permission Checker with Fault Recorder

This block sits after a page-table walker in a memory management unit. For every translation presented to it, it compares the three-bit permission field of the final page entry with the kind of access being made and the privilege of the requester. It then reports either a pass, with the read, write and execute rights the translation may be cached with, or an error code. When a translation fails, the block logs the failure in a status register and a fault address register. Unless the failure is suppressed, it also raises a trap request on the cycle after.

The walker supplies its own error code. A nonzero code means the walk itself failed, and the block then skips the permission check. A simple register port reads either logged register. Reading the status register clears it, so software collects each fault report exactly once. A status register that already holds a value when a new fault arrives is collapsed to the overflow bit before the new fault is merged in.

Top module: `perm_fault_unit`

## Requirements
- R1: The access index is {is_write, is_fetch, supervisor} (bit 2 write, bit 1 fetch, bit 0 set for supervisor). A user access to a page whose permission field is 6 or 7 yields error code 12 (privilege). Otherwise, an access that needs a right the page does not give yields code 8 (protection). A read needs R, a write needs W, a fetch needs X, and write+fetch needs both W and X. Every other case yields 0.
- R2: When the no-fault mode input is high and the access is a user access, a nonzero permission code is ignored. The translation then passes with err_code 0 and normal rights, and nothing is logged.
- R3: Granted rights on rights[2:0] = {R,W,X}. For permission values 0..7, the supervisor receives R, RW, RX, RWX, X, RW, RX, RWX. The user receives the same, except that 5, 6 and 7 give R, none and none.
- R4: On a passing translation whose modified input is low, the W right is cleared.
- R5: A nonzero walker code is a fault. It appears unchanged on err_code, and the permission check is skipped.
- R6: On a fault, a nonzero status register is first reduced to 1 (overflow bit). It is then ORed with (access index << 5) | err_code | 2. The fault address register loads the faulting address on the same edge.
- R7: If no-fault mode is high or traps are disabled, a fault grants rights 3'b111 and raises no trap. It is still logged.
- R8: Any other fault pulses trap_fetch (fetch accesses) or trap_data (all other accesses) for exactly one cycle, on the cycle after the fault.
- R9: A read with rd_sel=0 returns the status register and clears it on that edge, while rd_sel=1 returns the fault address without clearing it. A fault on the same cycle as a status read is logged into the cleared register, so no overflow bit is set.
- R10: After reset both registers read 0 and both trap outputs are low.
- R11: With chk_valid low, err_code and rights are 0, and no register or trap changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | A translation result is presented this cycle |
| acc_write | input | 1 | Access is a store |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Access comes from supervisor mode |
| perm | input | 3 | Permission field of the page entry |
| modified | input | 1 | Modified bit of the page entry |
| nofault_mode | input | 1 | No-fault mode enable |
| traps_en | input | 1 | Traps enabled |
| walk_err | input | ECW | Walker error code, 0 when the walk succeeded |
| fault_addr | input | AW | Virtual address of the access |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 selects status, 1 selects fault address |
| err_code | output | ECW | Resulting error code, 0 on pass |
| rights | output | 3 | Granted {R,W,X} rights |
| trap_fetch | output | 1 | Instruction-fault trap request |
| trap_data | output | 1 | Data-fault trap request |
| rd_data | output | AW | Read data, 0 when rd_en is low |

## Verification
A status register that is not cleared on a read shows up on the very next fault, as a stray overflow bit in the next status read. A missing collapse to the overflow bit shows up as stale access-index bits left over from an earlier fault. A fault address that is not loaded is visible on the first address read after the fault. A wrong trap register shows on trap_fetch or trap_data one cycle after the failing translation. Permission-table errors are combinational, so they appear on err_code and rights in the same cycle as the stimulus.

// File: rtl/perm_fault_unit.sv
module perm_fault_unit #(
  parameter int AW  = 32,
  parameter int ECW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           chk_valid,
  input  logic           acc_write,
  input  logic           acc_fetch,
  input  logic           acc_super,
  input  logic [2:0]     perm,
  input  logic           modified,
  input  logic           nofault_mode,
  input  logic           traps_en,
  input  logic [ECW-1:0] walk_err,
  input  logic [AW-1:0]  fault_addr,
  input  logic           rd_en,
  input  logic           rd_sel,
  output logic [ECW-1:0] err_code,
  output logic [2:0]     rights,
  output logic           trap_fetch,
  output logic           trap_data,
  output logic [AW-1:0]  rd_data
);

  localparam logic [2:0] RT_R = 3'b100;
  localparam logic [2:0] RT_W = 3'b010;
  localparam logic [2:0] RT_X = 3'b001;
  localparam logic [2:0] RT_ALL = 3'b111;
  localparam logic [ECW-1:0] EC_PROT = ECW'(8);
  localparam logic [ECW-1:0] EC_PRIV = ECW'(12);
  localparam int IDX_SHIFT = 5;

  logic [2:0]     acc_idx, page_rt, need_rt;
  logic [ECW-1:0] perm_ec;
  logic           walk_bad, perm_bad, fault, quiet;
  logic [AW-1:0]  fsr_q, far_q, fsr_base, log_word;

  assign acc_idx = {acc_write, acc_fetch, acc_super};
  assign need_rt = {~acc_write & ~acc_fetch, acc_write, acc_fetch};

  always_comb begin
    case (perm)
      3'd0: page_rt = RT_R;
      3'd1: page_rt = RT_R | RT_W;
      3'd2: page_rt = RT_R | RT_X;
      3'd3: page_rt = RT_ALL;
      3'd4: page_rt = RT_X;
      3'd5: page_rt = acc_super ? (RT_R | RT_W) : RT_R;
      3'd6: page_rt = acc_super ? (RT_R | RT_X) : 3'b000;
      default: page_rt = acc_super ? RT_ALL : 3'b000;
    endcase
  end

  always_comb begin
    if (!acc_super && perm[2:1] == 2'b11) perm_ec = EC_PRIV;
    else if ((need_rt & ~page_rt) != 3'b000) perm_ec = EC_PROT;
    else perm_ec = '0;
  end

  assign walk_bad = walk_err != '0;
  assign perm_bad = (perm_ec != '0) && !(nofault_mode && !acc_super);
  assign fault    = chk_valid && (walk_bad || perm_bad);
  assign quiet    = nofault_mode || !traps_en;

  always_comb begin
    err_code = '0;
    rights   = 3'b000;
    if (chk_valid) begin
      if (walk_bad) begin
        err_code = walk_err;
        rights   = quiet ? RT_ALL : 3'b000;
      end else if (perm_bad) begin
        err_code = perm_ec;
        rights   = quiet ? RT_ALL : 3'b000;
      end else begin
        rights = page_rt & ~(modified ? 3'b000 : RT_W);
      end
    end
  end

  assign fsr_base = (rd_en && !rd_sel) ? '0 : fsr_q;
  assign log_word = (AW'(acc_idx) << IDX_SHIFT) | AW'(err_code) | AW'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q      <= '0;
      far_q      <= '0;
      trap_fetch <= 1'b0;
      trap_data  <= 1'b0;
    end else begin
      if (fault) begin
        fsr_q <= ((fsr_base != '0) ? AW'(1) : '0) | log_word;
        far_q <= fault_addr;
      end else begin
        fsr_q <= fsr_base;
      end
      trap_fetch <= fault && !quiet && acc_fetch;
      trap_data  <= fault && !quiet && !acc_fetch;
    end
  end

  assign rd_data = rd_en ? (rd_sel ? far_q : fsr_q) : '0;

  a_r8_one_trap: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_fetch && trap_data));

  a_r8_fetch_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !quiet && acc_fetch) |=> trap_fetch);

  a_r7_quiet_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && quiet) |=> (!trap_fetch && !trap_data));

  a_r6_valid_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fsr_q[1]);

  a_r6_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (far_q == $past(fault_addr)));

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && !fault) |=> (fsr_q == '0));

  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_valid && !rd_en) |=> ($stable(fsr_q) && $stable(far_q)));

  a_r4_no_write_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !modified && !fault) |-> !rights[1]);

endmodule

// File: tb/sim_perm_fault_unit.sv
module sim_perm_fault_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int ECW = 10;

  logic clk = 0, rst_n = 0;
  logic chk_valid = 0, acc_write = 0, acc_fetch = 0, acc_super = 0;
  logic [2:0] perm = 0;
  logic modified = 0, nofault_mode = 0, traps_en = 1;
  logic [ECW-1:0] walk_err = 0;
  logic [AW-1:0] fault_addr = 0;
  logic rd_en = 0, rd_sel = 0;
  logic [ECW-1:0] err_code;
  logic [2:0] rights;
  logic trap_fetch, trap_data;
  logic [AW-1:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [AW-1:0] m_fsr = 0, m_far = 0;
  bit x_tf = 0, x_td = 0;

  int ec_tbl [64] = '{
    0,0,0,0,8,0,12,12,  0,0,0,0,8,0,0,0,
    8,8,0,0,0,8,12,12,  8,8,0,0,0,8,0,0,
    8,0,8,0,8,8,12,12,  8,0,8,0,8,0,8,0,
    8,8,8,0,8,8,12,12,  8,8,8,0,8,8,8,0 };
  logic [2:0] sup_rt [8] = '{3'b100,3'b110,3'b101,3'b111,3'b001,3'b110,3'b101,3'b111};
  logic [2:0] usr_rt [8] = '{3'b100,3'b110,3'b101,3'b111,3'b001,3'b100,3'b000,3'b000};

  perm_fault_unit #(.AW(AW), .ECW(ECW)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(bit cv, bit w, bit f, bit s, logic [2:0] p, bit m, bit nf, bit te,
                     logic [ECW-1:0] we, logic [AW-1:0] ad, bit re, bit rs, string tag);
    int idx, ec;
    bit flt, quiet;
    logic [2:0] rt;
    logic [AW-1:0] base;
    @(negedge clk);
    check({tag, " R8 trap_fetch"}, 64'(trap_fetch), 64'(x_tf));
    check({tag, " R8 trap_data"}, 64'(trap_data), 64'(x_td));
    chk_valid = cv; acc_write = w; acc_fetch = f; acc_super = s; perm = p;
    modified = m; nofault_mode = nf; traps_en = te; walk_err = we;
    fault_addr = ad; rd_en = re; rd_sel = rs;
    #1;
    idx = (int'(w) << 2) | (int'(f) << 1) | int'(s);
    ec = ec_tbl[idx*8 + int'(p)];
    if (nf && !s) ec = 0;
    quiet = nf || !te;
    flt = cv && (we != 0 || ec != 0);
    rt = 3'b000;
    if (cv) begin
      if (we != 0) ec = int'(we);
      if (flt) rt = quiet ? 3'b111 : 3'b000;
      else begin
        rt = s ? sup_rt[p] : usr_rt[p];
        if (!m) rt[1] = 1'b0;
      end
    end else ec = 0;
    check({tag, " R1/R5/R11 err_code"}, 64'(err_code), 64'(flt ? ec : 0));
    check({tag, " R3/R4/R7 rights"}, 64'(rights), 64'(rt));
    if (re) check({tag, " R9 rd_data"}, 64'(rd_data), 64'(rs ? m_far : m_fsr));
    else check({tag, " R9 rd_data idle"}, 64'(rd_data), 64'(0));
    @(posedge clk);
    base = (re && !rs) ? '0 : m_fsr;
    if (flt) begin
      m_fsr = ((base != 0) ? AW'(1) : AW'(0)) | (AW'(idx) << 5) | AW'(ec) | AW'(2);
      m_far = ad;
    end else m_fsr = base;
    x_tf = flt && !quiet && f;
    x_td = flt && !quiet && !f;
  endtask

  task automatic idle(string tag);
    cyc(0,0,0,1,0,1,0,1,0,0,0,0,tag);
  endtask

  initial begin
    int cnt = 0;
    while (!done) begin
      @(posedge clk);
      cnt++;
      if (cnt > 150000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected<150000", cnt);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd_en = 1; rd_sel = 0; #1;
    check("R10 status after reset", 64'(rd_data), 64'(0));
    rd_sel = 1; #1;
    check("R10 address after reset", 64'(rd_data), 64'(0));
    check("R10 traps after reset", 64'({trap_fetch, trap_data}), 64'(0));
    rd_en = 0;
    rst_n = 1;
    // R1 privilege code for user on perm 6, data trap R8
    cyc(1,0,0,0,3'd6,1,0,1,0,32'h1000,0,0,"dir-priv");
    idle("dir-idle");
    // R6 second fault collapses to overflow; fetch trap
    cyc(1,0,1,0,3'd0,1,0,1,0,32'h2000,0,0,"dir-ovf");
    cyc(0,0,0,1,0,1,0,1,0,0,1,0,"dir-rd-status");
    cyc(0,0,0,1,0,1,0,1,0,0,1,0,"dir-rd-cleared");
    cyc(0,0,0,1,0,1,0,1,0,0,1,1,"dir-rd-addr");
    // R2 user no-fault ignores permission error
    cyc(1,1,0,0,3'd0,1,1,1,0,32'h3000,1,0,"dir-nf-user");
    // R7 traps disabled gives full rights, still logged
    cyc(1,1,0,1,3'd0,1,0,0,0,32'h4000,0,0,"dir-quiet");
    // R9 fault with same-cycle status read: no overflow
    cyc(1,0,0,1,3'd4,1,0,1,0,32'h5000,1,0,"dir-rd-fault");
    cyc(0,0,0,1,0,1,0,1,0,0,1,0,"dir-rd-after");
    // R5 walker error passes through
    cyc(1,0,0,1,3'd3,1,0,1,10'h114,32'h6000,0,0,"dir-walk");
    // R4 write right withheld when clean
    cyc(1,0,0,1,3'd3,0,0,1,0,32'h7000,1,1,"dir-clean");
    cyc(1,1,1,1,3'd7,1,0,1,0,32'h8000,0,0,"dir-wf");
    idle("dir-end");
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom(i + 77) % 16);
      logic [ECW-1:0] we = (r == 0) ? ECW'((($urandom % 4) << 8) | (($urandom % 2) ? 16 : 4)) : '0;
      cyc(($urandom % 4) != 0, $urandom % 2, $urandom % 2, $urandom % 2, 3'($urandom),
          $urandom % 2, ($urandom % 5) == 0, ($urandom % 6) != 0, we, $urandom,
          ($urandom % 3) == 0, $urandom % 2, "rand");
    end
    idle("final");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule